// File: doc/BRIEF.md
# Serial Command Register Front End for a Sixteen-Channel Output Controller

This block is the serial target of a sixteen-channel output controller. A host shifts a 24-bit command frame in while the block shifts a 24-bit fault word out in the same frame. When the frame is framed off by the chip-select line, the block decodes the opcode and updates one of its control registers. The registers are on/off state, open-load current enable, over-voltage and thermal recovery policy, short-fault-protect disable, PWM enable and PWM AND/OR select. Every register is driven out in parallel for the output stage. That stage, along with fault detection, sits outside this block and feeds the per-channel fault flags and an over-voltage flag back in.

The serial pins are oversampled by a system clock that runs at least four times faster than the serial clock. Both the serial clock and chip select pass through synchronizer stages before their edges are detected. Data is received on the falling serial clock edge and moved out on the rising edge, most significant bit first. The shifter passes received bits on to its output, so devices can be chained. A 48-bit transfer returns the first 24 bits sent, which gives a loopback check.

Top module: `spi_cmd_if`

## Requirements
- R1: While `rst` is high, or while `clr_n` is low at a clock edge, every control register (the five 16-bit banks and both policy bits) becomes zero and `so_oe` is low while `cs_n` is high.
- R2: The opcode is frame bits 23..18 and the channel data is bits 15..0. Bit 15 maps to channel 15. Opcode 000000 loads bits 15..0 into `on_q`.
- R3: Opcode 000010 loads `olc_q`, 000110 loads `sfpd_q`, 001000 loads `pwm_en_q` and 001010 loads `andor_q`. Each opcode leaves every other register unchanged.
- R4: Opcode 000100 loads frame bit 16 into `ov_resume_q` and bit 17 into `therm_retry_q`. No 16-bit bank changes.
- R5: Opcode 001100 clears `on_q`, `sfpd_q`, `pwm_en_q` and `andor_q`. It keeps `olc_q`, `ov_resume_q` and `therm_retry_q`.
- R6: Any other opcode leaves every register unchanged.
- R7: The first 24 bits on `so` are the fault word, sampled when `cs_n` falls. Bit 23 is the OR of all faults, bit 22 is `ov_fault`, bits 21..16 are zero and bits 15..0 are `fault_in`. A change of the fault inputs after `cs_n` falls does not alter the word being sent.
- R8: `so_oe` is high only while `cs_n` is low. Serial clock pulses and `si` data while `cs_n` is high are not received.
- R9: When `cs_n` rises, the last 24 bits received are executed, whatever the number of bits in the frame.
- R10: In a 48-bit frame, the second 24 bits out of `so` equal the first 24 bits into `si`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Active-low clear of all registers, sampled on `clk` |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so`; low means high impedance |
| fault_in | input | 16 | Per-channel fault flags, 1 = fault |
| ov_fault | input | 1 | Over-voltage flag |
| on_q | output | 16 | Channel on/off register |
| olc_q | output | 16 | Open-load current enable register |
| sfpd_q | output | 16 | Short-fault-protect disable register |
| pwm_en_q | output | 16 | PWM enable register |
| andor_q | output | 16 | PWM combine select register (0 AND, 1 OR) |
| ov_resume_q | output | 1 | Resume after over-voltage |
| therm_retry_q | output | 1 | Retry after thermal shutdown |

## Verification
Random frames mix all seven legal opcodes with arbitrary 6-bit codes. They carry random channel data and random fault inputs. A wrong bank selection, a reset command that clears too much or too little, or an illegal code that is acted on therefore shows up in a register other than the one addressed. Fault inputs are changed in the middle of each frame, which separates a capture made at the chip-select fall from a live view of the inputs. Directed frames cover the bit 15 and bit 0 channel mapping, a 32-bit over-length frame and a 48-bit loopback. A zero-length frame that follows serial clocking with chip select high must re-execute the previously received command rather than the bits clocked while deselected.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CMD_OP_W   = 6;
    localparam int DEF_OUTS   = 16;
    localparam int DEF_FRAME  = 24;
    localparam int BANK_COUNT = 5;

    typedef enum logic [CMD_OP_W-1:0] {
        OP_ONOFF  = 6'b000000,
        OP_OLC    = 6'b000010,
        OP_GLOBAL = 6'b000100,
        OP_SFPD   = 6'b000110,
        OP_PWM    = 6'b001000,
        OP_ANDOR  = 6'b001010,
        OP_RESET  = 6'b001100
    } op_e;

    typedef struct packed {
        logic therm_retry;
        logic ov_resume;
    } glob_t;

    // Bank index -> opcode that loads it (0 on, 1 olc, 2 sfpd, 3 pwm, 4 andor)
    function automatic op_e bank_op(input int idx);
        case (idx)
            0:       return OP_ONOFF;
            1:       return OP_OLC;
            2:       return OP_SFPD;
            3:       return OP_PWM;
            default: return OP_ANDOR;
        endcase
    endfunction

    // Bank index -> cleared by the reset command
    function automatic logic bank_cleared_by_cmd(input int idx);
        return (idx != 1);
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_pin,
    input  logic csn_pin,
    input  logic si_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_act,
    output logic si_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_c, csn_c, si_c;
    logic              sclk_d, csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_c <= '0;
            csn_c  <= '1;
            si_c   <= '0;
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_c <= {sclk_c[STAGES-2:0], sclk_pin};
            csn_c  <= {csn_c[STAGES-2:0], csn_pin};
            si_c   <= {si_c[STAGES-2:0], si_pin};
            sclk_d <= sclk_c[TOP];
            csn_d  <= csn_c[TOP];
        end
    end

    assign cs_act    = !csn_c[TOP];
    assign cs_fall   = !csn_c[TOP] && csn_d;
    assign cs_rise   = csn_c[TOP] && !csn_d;
    assign sclk_rise = cs_act && sclk_c[TOP] && !sclk_d;
    assign sclk_fall = cs_act && !sclk_c[TOP] && sclk_d;
    assign si_s      = si_c[TOP];

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
    parameter int N_OUT   = spi_cmd_pkg::DEF_OUTS,
    parameter int FRAME_W = spi_cmd_pkg::DEF_FRAME
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               cs_fall,
    input  logic               cs_act,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               si_s,
    input  logic [N_OUT-1:0]   fault_in,
    input  logic               ov_in,
    output logic [FRAME_W-1:0] rx_q,
    output logic               so,
    output logic               so_oe
);
    localparam int PAD = FRAME_W - N_OUT - 2;

    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] status;
    logic               armed;

    assign status = {(|fault_in) | ov_in, ov_in, {PAD{1'b0}}, fault_in};

    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            rx_q  <= '0;
            tx_q  <= '0;
            armed <= 1'b0;
        end else if (cs_fall) begin
            tx_q  <= status;
            armed <= 1'b0;
        end else begin
            if (sclk_fall) begin
                rx_q  <= {rx_q[FRAME_W-2:0], si_s};
                armed <= 1'b1;
            end
            // first rising edge keeps the MSB that was loaded at select
            if (sclk_rise && armed)
                tx_q <= {tx_q[FRAME_W-2:0], rx_q[0]};
        end
    end

    assign so    = tx_q[FRAME_W-1];
    assign so_oe = cs_act;

    // R7: reserved field of the captured word is zero
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && clr_n) |=> (tx_q[FRAME_W-3:N_OUT] == '0));

    // R7: summary bit agrees with the captured flags
    a_r7_any_summary: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && clr_n) |=> (tx_q[FRAME_W-1] == (|tx_q[FRAME_W-2:0])));

    // R8: nothing is received while deselected
    a_r8_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && clr_n) |=> $stable(rx_q));

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int N_OUT   = DEF_OUTS,
    parameter int FRAME_W = DEF_FRAME
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               exec,
    input  logic [FRAME_W-1:0] cmd,
    output logic [N_OUT-1:0]   on_q,
    output logic [N_OUT-1:0]   olc_q,
    output logic [N_OUT-1:0]   sfpd_q,
    output logic [N_OUT-1:0]   pwm_q,
    output logic [N_OUT-1:0]   andor_q,
    output glob_t              glob_q
);
    op_e              op;
    logic [N_OUT-1:0] bank_q [BANK_COUNT];

    assign op = op_e'(cmd[FRAME_W-1 -: CMD_OP_W]);

    for (genvar gi = 0; gi < BANK_COUNT; gi++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst || !clr_n)
                bank_q[gi] <= '0;
            else if (exec) begin
                if (op == bank_op(gi))
                    bank_q[gi] <= cmd[N_OUT-1:0];
                else if (op == OP_RESET && bank_cleared_by_cmd(gi))
                    bank_q[gi] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !clr_n)
            glob_q <= '0;
        else if (exec && op == OP_GLOBAL) begin
            glob_q.ov_resume   <= cmd[N_OUT];
            glob_q.therm_retry <= cmd[N_OUT+1];
        end
    end

    assign on_q    = bank_q[0];
    assign olc_q   = bank_q[1];
    assign sfpd_q  = bank_q[2];
    assign pwm_q   = bank_q[3];
    assign andor_q = bank_q[4];

    // R1: clear input empties everything
    a_r1_clear_all: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (on_q == '0 && olc_q == '0 && sfpd_q == '0 &&
                    pwm_q == '0 && andor_q == '0 && glob_q == '0));

    // R6: registers hold between commands
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!exec && clr_n) |=> ($stable(on_q) && $stable(olc_q) && $stable(sfpd_q) &&
                              $stable(pwm_q) && $stable(andor_q) && $stable(glob_q)));

    // R5: reset command keeps open-load enable and policy bits
    a_r5_cmd_reset_keeps: assert property (@(posedge clk) disable iff (rst)
        (exec && clr_n && op == OP_RESET) |=>
            (on_q == '0 && pwm_q == '0 && $stable(olc_q) && $stable(glob_q)));

    // R4: policy command touches no channel bank
    a_r4_global_only: assert property (@(posedge clk) disable iff (rst)
        (exec && clr_n && op == OP_GLOBAL) |=> ($stable(on_q) && $stable(olc_q)));

endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
    import spi_cmd_pkg::*;
#(
    parameter int N_OUT       = DEF_OUTS,
    parameter int FRAME_W     = DEF_FRAME,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             si,
    output logic             so,
    output logic             so_oe,
    input  logic [N_OUT-1:0] fault_in,
    input  logic             ov_fault,
    output logic [N_OUT-1:0] on_q,
    output logic [N_OUT-1:0] olc_q,
    output logic [N_OUT-1:0] sfpd_q,
    output logic [N_OUT-1:0] pwm_en_q,
    output logic [N_OUT-1:0] andor_q,
    output logic             ov_resume_q,
    output logic             therm_retry_q
);
    logic               sclk_rise, sclk_fall, cs_fall, cs_rise, cs_act, si_s;
    logic [FRAME_W-1:0] rx_q;
    glob_t              glob_q;

    spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_pin(sclk), .csn_pin(cs_n), .si_pin(si),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .si_s(si_s)
    );

    spi_cmd_shift #(.N_OUT(N_OUT), .FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .clr_n(clr_n),
        .cs_fall(cs_fall), .cs_act(cs_act),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_s(si_s),
        .fault_in(fault_in), .ov_in(ov_fault),
        .rx_q(rx_q), .so(so), .so_oe(so_oe)
    );

    spi_cmd_regs #(.N_OUT(N_OUT), .FRAME_W(FRAME_W)) u_regs (
        .clk(clk), .rst(rst), .clr_n(clr_n),
        .exec(cs_rise), .cmd(rx_q),
        .on_q(on_q), .olc_q(olc_q), .sfpd_q(sfpd_q),
        .pwm_q(pwm_en_q), .andor_q(andor_q), .glob_q(glob_q)
    );

    assign ov_resume_q   = glob_q.ov_resume;
    assign therm_retry_q = glob_q.therm_retry;

endmodule

// File: tb/spi_cmd_if_tb.sv
module spi_cmd_if_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic [15:0] fault_in = '0;
    logic        ov_fault = 1'b0;
    logic [15:0] on_q, olc_q, sfpd_q, pwm_en_q, andor_q;
    logic        ov_resume_q, therm_retry_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_on, m_olc, m_sfpd, m_pwm, m_andor;
    logic        m_ovr, m_thr;

    always #2 clk = ~clk;

    spi_cmd_if u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n),
        .sclk(sclk), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
        .fault_in(fault_in), .ov_fault(ov_fault),
        .on_q(on_q), .olc_q(olc_q), .sfpd_q(sfpd_q), .pwm_en_q(pwm_en_q),
        .andor_q(andor_q), .ov_resume_q(ov_resume_q), .therm_retry_q(therm_retry_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input logic [5:0] op, input logic [1:0] hi,
                                       input logic [15:0] d);
        return {op, hi, d};
    endfunction

    function automatic logic [23:0] fault_word(input logic [15:0] f, input logic ov);
        return {(|f) | ov, ov, 6'b0, f};
    endfunction

    task automatic model_apply(input logic [23:0] c);
        case (c[23:18])
            6'b000000: m_on    = c[15:0];
            6'b000010: m_olc   = c[15:0];
            6'b000100: begin m_ovr = c[16]; m_thr = c[17]; end
            6'b000110: m_sfpd  = c[15:0];
            6'b001000: m_pwm   = c[15:0];
            6'b001010: m_andor = c[15:0];
            6'b001100: begin m_on = '0; m_sfpd = '0; m_pwm = '0; m_andor = '0; end
            default: ;
        endcase
    endtask

    task automatic model_zero();
        m_on = '0; m_olc = '0; m_sfpd = '0; m_pwm = '0; m_andor = '0;
        m_ovr = 1'b0; m_thr = 1'b0;
    endtask

    task automatic chk_regs(input string req);
        chk(req, "on_q", 64'(on_q), 64'(m_on));
        chk(req, "olc_q", 64'(olc_q), 64'(m_olc));
        chk(req, "sfpd_q", 64'(sfpd_q), 64'(m_sfpd));
        chk(req, "pwm_en_q", 64'(pwm_en_q), 64'(m_pwm));
        chk(req, "andor_q", 64'(andor_q), 64'(m_andor));
        chk(req, "ov_resume_q", 64'(ov_resume_q), 64'(m_ovr));
        chk(req, "therm_retry_q", 64'(therm_retry_q), 64'(m_thr));
    endtask

    // Frame of nbits; din[nbits-1] goes first. SO is sampled just before each fall.
    task automatic xfer(input int nbits, input logic [63:0] din, input bit disturb,
                        output logic [63:0] dout);
        dout = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            si   = din[i];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            dout = {dout[62:0], so};
            if (disturb && i == nbits - 2) begin
                fault_in = 16'($urandom);
                ov_fault = 1'($urandom);
            end
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] c, input string req);
        logic [63:0] d;
        logic [23:0] expw;
        expw = fault_word(fault_in, ov_fault);
        xfer(24, 64'(c), 1'b1, d);
        chk("R7", "fault word", d, 64'(expw));
        model_apply(c);
        chk_regs(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [23:0] a, b;
        void'($urandom(32'h5eed_c0de));
        model_zero();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk_regs("R1");
        chk("R1", "so_oe idle", 64'(so_oe), 64'd0);

        // R2 channel mapping: bit 15 and bit 0
        send(mk(6'b000000, 2'b11, 16'h8001), "R2");
        send(mk(6'b000000, 2'b00, 16'h4000), "R2");

        // R3 each bank
        send(mk(6'b000010, 2'b00, 16'hA5A5), "R3");
        send(mk(6'b000110, 2'b00, 16'h0F0F), "R3");
        send(mk(6'b001000, 2'b00, 16'h3C3C), "R3");
        send(mk(6'b001010, 2'b00, 16'hFF00), "R3");

        // R4 policy bits separately
        send(mk(6'b000100, 2'b01, 16'hFFFF), "R4");
        send(mk(6'b000100, 2'b10, 16'h0000), "R4");

        // R5 reset command
        send(mk(6'b000000, 2'b00, 16'h1234), "R5");
        send(mk(6'b001100, 2'b11, 16'hFFFF), "R5");

        // R6 undefined codes
        send(mk(6'b000000, 2'b00, 16'h00FF), "R6");
        send(mk(6'b000001, 2'b00, 16'h1111), "R6");
        send(mk(6'b111111, 2'b11, 16'h2222), "R6");
        send(mk(6'b001110, 2'b00, 16'h3333), "R6");

        // R7 fault word with only over-voltage, then only one channel
        fault_in = '0; ov_fault = 1'b1;
        xfer(24, 64'(mk(6'b010000, 2'b00, 16'h0)), 1'b0, d);
        chk("R7", "ov only word", d, 64'h00C00000);
        fault_in = 16'h0001; ov_fault = 1'b0;
        xfer(24, 64'(mk(6'b010000, 2'b00, 16'h0)), 1'b0, d);
        chk("R7", "ch0 only word", d, 64'h00800001);

        // R8 enable follows select; deselected clocks are not received
        a = mk(6'b000000, 2'b00, 16'hBEEF);
        send(a, "R8");
        b = mk(6'b000000, 2'b00, 16'h0420);
        chk("R8", "so_oe deselected", 64'(so_oe), 64'd0);
        for (int i = 23; i >= 0; i--) begin
            si = b[i]; sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        chk("R8", "so_oe selected", 64'(so_oe), 64'd1);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        chk("R8", "on_q after zero-bit frame", 64'(on_q), 64'hBEEF);

        // R9 over-length frame executes last 24 bits
        xfer(32, {32'h0, 8'hFF, mk(6'b001000, 2'b00, 16'h5AA5)}, 1'b0, d);
        model_apply(mk(6'b001000, 2'b00, 16'h5AA5));
        chk_regs("R9");

        // R10 48-bit loopback
        a = mk(6'b001010, 2'b01, 16'hC3C3);
        b = mk(6'b000010, 2'b00, 16'h7E7E);
        fault_in = 16'h8100; ov_fault = 1'b0;
        xfer(48, {16'h0, a, b}, 1'b0, d);
        chk("R10", "second half out", 64'(d[23:0]), 64'(a));
        chk("R10", "first half out", 64'(d[47:24]), 64'h00808100);
        model_apply(b);
        chk_regs("R10");

        // Random frames
        for (int n = 0; n < 30; n++) begin
            logic [5:0] op;
            int sel;
            string tag;
            sel = int'($urandom % 8);
            op = (sel < 7) ? 6'(sel * 2) : 6'($urandom);
            case (op)
                6'b000000: tag = "R2";
                6'b000010, 6'b000110, 6'b001000, 6'b001010: tag = "R3";
                6'b000100: tag = "R4";
                6'b001100: tag = "R5";
                default:   tag = "R6";
            endcase
            fault_in = 16'($urandom);
            ov_fault = 1'($urandom);
            send(mk(op, 2'($urandom), 16'($urandom)), tag);
        end

        // R1 clear input
        clr_n = 1'b0;
        repeat (2) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        model_zero();
        chk_regs("R1");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule